// File: doc/BRIEF.md
# Soft-Start Duty Limiter

This block sits between a digital control loop and a PWM power stage and limits the duty-cycle command that reaches the stage during start-up. An internal ramp register stays at zero until three readiness flags are all high: undervoltage lockout cleared, supply good and reference good. Once they are, the ramp climbs at a constant programmable rate. A step-size input is added to the ramp once every `TICK_DIV` clocks. The ramp saturates at full scale and never wraps.

The ramp has a dead band. The fixed amount `OFFSET` is subtracted from it, and the result is clamped at zero and at the largest duty code. The duty actually passed on is the smaller of this ramp-derived limit and the external loop command. Once the loop has settled and asks for less duty than the ramp allows, it takes control.

A shutdown input forces the output to zero in the same cycle and clears the ramp. Releasing shutdown starts a fresh soft-start from zero. Dropping any readiness flag has the same effect.

Top module: `ssr_duty_limiter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `duty_out` is 0 and the ramp is 0.
- R2: While any of `uvlo_ok`, `vcc_ok`, `ref_ok` is low, the ramp is held at 0 and `duty_out` is 0. A flag dropping mid-ramp clears the ramp on the next edge.
- R3: While all three flags are high and `shutdown` is low, the ramp grows by `step_size` exactly once every `TICK_DIV` clocks. The first step lands on the `TICK_DIV`-th rising edge after enabling. Between steps the ramp is unchanged.
- R4: While the ramp is at or below `OFFSET` (default 128), `duty_out` is 0.
- R5: When enabled, `duty_out` equals min(max(ramp − `OFFSET`, 0) clamped to 2^`DUTY_W` − 1, `loop_duty`).
- R6: While `shutdown` is high, `duty_out` is 0 in that same cycle, and the ramp is 0 after the next edge.
- R7: After `shutdown` falls, the ramp restarts from 0, and the first step comes `TICK_DIV` clocks later.
- R8: The ramp saturates at 2^`RAMP_W` − 1 (default 2047) and does not wrap.
- R9: With `step_size` = 0 the ramp holds its value while enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| uvlo_ok | input | 1 | Undervoltage lockout cleared |
| vcc_ok | input | 1 | Supply rail good |
| ref_ok | input | 1 | Reference good |
| shutdown | input | 1 | Forces duty to zero and clears the ramp |
| step_size | input | STEP_W | Ramp increment applied every TICK_DIV clocks |
| loop_duty | input | DUTY_W | Duty command from the control loop |
| duty_out | output | DUTY_W | Limited duty command |

## Verification
The loop command is held at full scale while the ramp crosses the dead band and rises. This shows the offset subtraction and the step timing apart from the minimum selection. The loop command is then lowered, and later varied pseudo-randomly, to show that the minimum follows whichever operand is smaller. Flags are dropped one at a time, shutdown is pulsed, and a zero step is applied. These separate clearing the ramp from merely gating the output. A large step with a full-scale loop command drives the ramp into saturation, where wraparound would show up as a sudden drop in duty.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef struct packed {
    logic uvlo;
    logic vcc;
    logic vref;
  } ready_t;

  // Saturating add of two unsigned values against an upper limit.
  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned lim);
    longint unsigned s;
    s = longint'(a) + longint'(b);
    if (s > longint'(lim)) return lim;
    return int'(s);
  endfunction

  // Remove the dead band and clamp into the duty range.
  function automatic int unsigned band_clamp(input int unsigned ramp,
                                             input int unsigned off,
                                             input int unsigned dmax);
    int unsigned d;
    d = (ramp > off) ? ramp - off : 0;
    if (d > dmax) d = dmax;
    return d;
  endfunction

  function automatic int unsigned umin(input int unsigned a,
                                       input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/ssr_qualify.sv
module ssr_qualify
  import ssr_pkg::*;
(
  input  ready_t ready,
  input  logic   shutdown,
  output logic   ready_all,
  output logic   run_en
);
  assign ready_all = ready.uvlo & ready.vcc & ready.vref;
  assign run_en    = ready_all & ~shutdown;
endmodule

// File: rtl/ssr_tick.sv
module ssr_tick #(
  parameter int TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic tick
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick = run_en;
    end else begin : g_div
      localparam int CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (!run_en) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign tick = run_en && (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/ssr_ramp.sv
module ssr_ramp
  import ssr_pkg::*;
#(
  parameter int RAMP_W = 11,
  parameter int STEP_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              tick,
  input  logic [STEP_W-1:0] step_size,
  output logic [RAMP_W-1:0] ramp
);
  localparam int unsigned RAMP_MAX = (1 << RAMP_W) - 1;

  logic [RAMP_W-1:0] ramp_nx;

  always_comb begin
    ramp_nx = RAMP_W'(sat_add(32'(ramp), 32'(step_size), RAMP_MAX));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ramp <= '0;
    end else if (!run_en) begin
      ramp <= '0;
    end else if (tick) begin
      ramp <= ramp_nx;
    end
  end
endmodule

// File: rtl/ssr_select.sv
module ssr_select
  import ssr_pkg::*;
#(
  parameter int RAMP_W = 11,
  parameter int DUTY_W = 10,
  parameter int OFFSET = 128
) (
  input  logic              run_en,
  input  logic [RAMP_W-1:0] ramp,
  input  logic [DUTY_W-1:0] loop_duty,
  output logic [DUTY_W-1:0] ramp_limit,
  output logic [DUTY_W-1:0] duty
);
  localparam int unsigned DUTY_MAX = (1 << DUTY_W) - 1;

  always_comb begin
    ramp_limit = DUTY_W'(band_clamp(32'(ramp), OFFSET, DUTY_MAX));
    if (run_en) begin
      duty = DUTY_W'(umin(32'(ramp_limit), 32'(loop_duty)));
    end else begin
      duty = '0;
    end
  end
endmodule

// File: rtl/ssr_duty_limiter.sv
module ssr_duty_limiter
  import ssr_pkg::*;
#(
  parameter int DUTY_W   = 10,
  parameter int RAMP_W   = 11,
  parameter int STEP_W   = 6,
  parameter int TICK_DIV = 4,
  parameter int OFFSET   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              uvlo_ok,
  input  logic              vcc_ok,
  input  logic              ref_ok,
  input  logic              shutdown,
  input  logic [STEP_W-1:0] step_size,
  input  logic [DUTY_W-1:0] loop_duty,
  output logic [DUTY_W-1:0] duty_out
);
  ready_t            ready;
  logic              ready_all;
  logic              run_en;
  logic              tick;
  logic [RAMP_W-1:0] ramp_q;
  logic [DUTY_W-1:0] ramp_limit;

  assign ready = '{uvlo: uvlo_ok, vcc: vcc_ok, vref: ref_ok};

  ssr_qualify u_qual (
    .ready    (ready),
    .shutdown (shutdown),
    .ready_all(ready_all),
    .run_en   (run_en)
  );

  ssr_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run_en(run_en),
    .tick  (tick)
  );

  ssr_ramp #(.RAMP_W(RAMP_W), .STEP_W(STEP_W)) u_ramp (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_en   (run_en),
    .tick     (tick),
    .step_size(step_size),
    .ramp     (ramp_q)
  );

  ssr_select #(.RAMP_W(RAMP_W), .DUTY_W(DUTY_W), .OFFSET(OFFSET)) u_sel (
    .run_en    (run_en),
    .ramp      (ramp_q),
    .loop_duty (loop_duty),
    .ramp_limit(ramp_limit),
    .duty      (duty_out)
  );
endmodule

// File: rtl/ssr_duty_limiter_chk.sv
module ssr_duty_limiter_chk #(
  parameter int DUTY_W = 10,
  parameter int RAMP_W = 11,
  parameter int OFFSET = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              shutdown,
  input logic              ready_all,
  input logic              run_en,
  input logic              tick,
  input logic [RAMP_W-1:0] ramp,
  input logic [DUTY_W-1:0] loop_duty,
  input logic [DUTY_W-1:0] duty_out
);
  localparam logic [RAMP_W-1:0] RMAX = '1;

  p_hold_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_all |=> ramp == '0);

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !tick) |=> $stable(ramp));

  p_monotonic_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |=> ramp >= $past(ramp));

  p_dead_band_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(ramp) <= OFFSET) |-> duty_out == '0);

  p_below_loop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    duty_out <= loop_duty);

  p_sd_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |-> duty_out == '0);

  p_sd_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown |=> ramp == '0);

  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && ramp == RMAX) |=> ramp == RMAX);
endmodule

bind ssr_duty_limiter ssr_duty_limiter_chk #(
  .DUTY_W(DUTY_W), .RAMP_W(RAMP_W), .OFFSET(OFFSET)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .shutdown (shutdown),
  .ready_all(ready_all),
  .run_en   (run_en),
  .tick     (tick),
  .ramp     (ramp_q),
  .loop_duty(loop_duty),
  .duty_out (duty_out)
);

// File: tb/ssr_duty_limiter_tb.sv
module ssr_duty_limiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DUTY_W = 10;
  localparam int RAMP_W = 11;
  localparam int STEP_W = 6;
  localparam int TICK_DIV = 4;
  localparam int OFFSET = 128;
  localparam int RAMP_TOP = (1 << RAMP_W) - 1;
  localparam int DUTY_TOP = (1 << DUTY_W) - 1;

  logic clk = 0;
  logic rst_n = 0;
  logic uvlo_ok = 0, vcc_ok = 0, ref_ok = 0, shutdown = 0;
  logic [STEP_W-1:0] step_size = '0;
  logic [DUTY_W-1:0] loop_duty = '0;
  logic [DUTY_W-1:0] duty_out;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_ramp = 0;
  int m_phase = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssr_duty_limiter #(
    .DUTY_W(DUTY_W), .RAMP_W(RAMP_W), .STEP_W(STEP_W),
    .TICK_DIV(TICK_DIV), .OFFSET(OFFSET)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .uvlo_ok(uvlo_ok), .vcc_ok(vcc_ok),
    .ref_ok(ref_ok), .shutdown(shutdown), .step_size(step_size),
    .loop_duty(loop_duty), .duty_out(duty_out)
  );

  function automatic bit enabled();
    return uvlo_ok && vcc_ok && ref_ok && !shutdown;
  endfunction

  // reference: elapsed enabled clocks counted in m_phase
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ramp = 0;
      m_phase = 0;
    end else if (!enabled()) begin
      m_ramp = 0;
      m_phase = 0;
    end else begin
      m_phase = m_phase + 1;
      if (m_phase == TICK_DIV) begin
        m_phase = 0;
        m_ramp = m_ramp + int'(step_size);
        if (m_ramp > RAMP_TOP) m_ramp = RAMP_TOP;
      end
    end
  end

  function automatic int expected();
    int lim;
    if (!enabled()) return 0;
    lim = m_ramp - OFFSET;
    if (lim < 0) lim = 0;
    if (lim > DUTY_TOP) lim = DUTY_TOP;
    return (int'(loop_duty) < lim) ? int'(loop_duty) : lim;
  endfunction

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (int'(duty_out) != expected()) begin
        fails++;
        $display("FAIL %s: duty_out=%0d expected=%0d (ramp model %0d)",
                 cur_req, duty_out, expected(), m_ramp);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    loop_duty = DUTY_W'(DUTY_TOP);
    step_size = 6'd8;
    // R1: reset state
    cur_req = "R1";
    run(4);
    @(negedge clk) rst_n = 1;
    run(3);
    // R2: two flags only, ramp held
    cur_req = "R2";
    uvlo_ok = 1; vcc_ok = 1;
    run(20);
    // R4 then R3/R5 rising through dead band
    cur_req = "R4";
    ref_ok = 1;
    run(64);
    cur_req = "R3";
    run(100);
    // R5: loop takes control
    cur_req = "R5";
    loop_duty = 10'd200;
    run(40);
    // R2: drop a flag mid-ramp, then restore
    cur_req = "R2";
    vcc_ok = 0;
    run(3);
    vcc_ok = 1;
    cur_req = "R3";
    run(80);
    ref_ok = 0;
    cur_req = "R2";
    run(2);
    ref_ok = 1;
    uvlo_ok = 0;
    run(2);
    uvlo_ok = 1;
    loop_duty = DUTY_W'(DUTY_TOP);
    cur_req = "R3";
    run(90);
    // R9: zero step holds ramp
    cur_req = "R9";
    step_size = '0;
    run(30);
    // R8: saturation
    cur_req = "R8";
    step_size = 6'd63;
    run(200);
    // R6: shutdown
    cur_req = "R6";
    shutdown = 1;
    run(10);
    // R7: restart
    cur_req = "R7";
    shutdown = 0;
    step_size = 6'd20;
    run(80);
    // R5: varying loop command
    cur_req = "R5";
    for (int k = 0; k < 100; k++) begin
      loop_duty = DUTY_W'((k * 397 + 51) % (DUTY_TOP + 1));
      run(1);
    end
    cur_req = "R6";
    shutdown = 1;
    run(1);
    shutdown = 0;
    cur_req = "R7";
    run(20);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule